// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the sequence of column addresses that a synchronous DRAM walks through during one read or write burst. A load strobe supplies the first column together with the burst length and burst ordering held in the mode register. From the next clock onward, the block presents one column address per cycle, with a valid flag.

For the fixed lengths of 2, 4 and 8, addresses wrap inside the aligned block of that size. The ordering is either sequential or interleaved. A full-page burst steps through all 256 columns of the open row. It keeps wrapping until a terminate request ends it or a new column command replaces it. A last-beat flag marks the final address of every fixed-length burst. A new load on any cycle restarts the sequence from the new column.

Top module: `burst_colgen`

## Requirements
- R1: While reset is high and on the first cycle after it, `col_valid_o` and `last_o` are 0.
- R2: A cycle with `load_i` high makes `col_valid_o` 1 on the next clock, with `col_o` equal to the loaded `start_col_i`.
- R3: One address is presented per clock. `blen_i` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats, and code 7 gives a full page.
- R4: With `btype_i` = 0 (sequential) and a fixed length L, beat k shows the upper column bits of the start unchanged. The low log2(L) bits equal (start + k) mod L.
- R5: With `btype_i` = 1 (interleaved) and a fixed length L, beat k shows the upper column bits of the start unchanged. The low log2(L) bits equal start XOR k.
- R6: `last_o` is 1 exactly on the final beat of a fixed-length burst. `col_valid_o` is 0 on the following clock unless a load arrived in the final cycle.
- R7: In full-page mode, beat k shows (start + k) mod 256, whatever `btype_i` is. The burst runs on past 256 beats, and `last_o` stays 0.
- R8: `term_i` high during an active burst makes `col_valid_o` 0 on the next clock. When `load_i` is also high in that cycle, the load takes priority.
- R9: A load during an active burst restarts the sequence from the new column, using the new length and ordering.
- R10: The reserved `blen_i` codes 4, 5 and 6 give a single beat, with `last_o` high on that beat.
- R11: `blen_i` and `btype_i` are sampled only in load cycles. Changing them during a burst has no effect on the addresses or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Column command strobe: start a new burst |
| start_col_i | input | 8 | First column of the burst |
| term_i | input | 1 | Stop the burst in progress |
| blen_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page, 4-6:1) |
| btype_i | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| col_o | output | 8 | Current column address |
| col_valid_o | output | 1 | `col_o` holds a burst address |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The assertions assume that `term_i` and `load_i` are only meaningful while reset is low. They also assume that the mode inputs matter only in a load cycle, so they place no constraint on `blen_i` or `btype_i` at other times. The stimulus changes inputs only between clock edges. It deliberately scrambles the mode inputs during bursts, and it raises terminate and load together in the same cycle so that the priority rule is exercised rather than avoided.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

    localparam int COL_W   = 8;
    localparam int BLEN_W  = 3;

    localparam logic [BLEN_W-1:0] BLEN_PAGE = 3'd7;

    typedef struct packed {
        logic             page;
        logic             ilv;
        logic [COL_W-1:0] mask;
    } burst_cfg_t;

    function automatic burst_cfg_t decode_cfg(input logic [BLEN_W-1:0] code,
                                              input logic ilv);
        burst_cfg_t c;
        c.page = (code == BLEN_PAGE);
        c.ilv  = ilv & ~c.page;
        case (code)
            3'd1:    c.mask = COL_W'(1);
            3'd2:    c.mask = COL_W'(3);
            3'd3:    c.mask = COL_W'(7);
            3'd7:    c.mask = '1;
            default: c.mask = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/colgen_seq.sv
module colgen_seq
    import sdram_colgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              term_i,
    input  logic [BLEN_W-1:0] blen_i,
    input  logic              btype_i,
    input  logic [COL_W-1:0]  start_col_i,
    output logic              active_o,
    output logic [COL_W-1:0]  beat_o,
    output logic [COL_W-1:0]  start_o,
    output burst_cfg_t        cfg_o,
    output logic              last_o
);

    logic             active_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] start_q;
    burst_cfg_t       cfg_q;

    always_comb begin
        last_o = active_q && !cfg_q.page && (beat_q == cfg_q.mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            beat_q   <= '0;
            start_q  <= '0;
            cfg_q    <= '0;
        end else if (load_i) begin
            active_q <= 1'b1;
            beat_q   <= '0;
            start_q  <= start_col_i;
            cfg_q    <= decode_cfg(blen_i, btype_i);
        end else if (active_q) begin
            if (term_i || last_o) begin
                active_q <= 1'b0;
            end else begin
                beat_q <= beat_q + COL_W'(1);
            end
        end
    end

    assign active_o = active_q;
    assign beat_o   = beat_q;
    assign start_o  = start_q;
    assign cfg_o    = cfg_q;

    // R8: terminate without load ends the burst on the next clock
    a_r8_term_stops: assert property (@(posedge clk) disable iff (rst)
        (term_i && !load_i) |=> !active_q);

    // R6: last beat without load is followed by an idle cycle
    a_r6_last_then_idle: assert property (@(posedge clk) disable iff (rst)
        (last_o && !load_i) |=> !active_q);

    // R3: an active burst with no stop condition advances by one beat
    a_r3_one_step: assert property (@(posedge clk) disable iff (rst)
        (active_q && !load_i && !term_i && !last_o) |=>
            (active_q && beat_q == $past(beat_q) + COL_W'(1)));

    // R11: the latched configuration only changes on a load
    a_r11_cfg_held: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(cfg_q));

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
    import sdram_colgen_pkg::*;
(
    input  logic [COL_W-1:0] start_i,
    input  logic [COL_W-1:0] beat_i,
    input  burst_cfg_t       cfg_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    always_comb begin
        low_seq = (start_i + beat_i) & cfg_i.mask;
        low_ilv = (start_i ^ beat_i) & cfg_i.mask;
        col_o   = (start_i & ~cfg_i.mask) | (cfg_i.ilv ? low_ilv : low_seq);
    end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import sdram_colgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic              term_i,
    input  logic [BLEN_W-1:0] blen_i,
    input  logic              btype_i,
    output logic [COL_W-1:0]  col_o,
    output logic              col_valid_o,
    output logic              last_o
);

    logic             active;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] start;
    burst_cfg_t       cfg;
    logic             last;

    colgen_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load_i),
        .term_i      (term_i),
        .blen_i      (blen_i),
        .btype_i     (btype_i),
        .start_col_i (start_col_i),
        .active_o    (active),
        .beat_o      (beat),
        .start_o     (start),
        .cfg_o       (cfg),
        .last_o      (last)
    );

    colgen_addr_map u_map (
        .start_i (start),
        .beat_i  (beat),
        .cfg_i   (cfg),
        .col_o   (col_o)
    );

    assign col_valid_o = active;
    assign last_o      = last;

    // R2: a load presents its start column on the next clock
    a_r2_load_start: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (col_valid_o && col_o == $past(start_col_i)));

    // R6: the last-beat flag only appears with a valid address
    a_r6_last_valid: assert property (@(posedge clk) disable iff (rst)
        last_o |-> col_valid_o);

    // R7: full-page bursts never flag a last beat
    a_r7_page_no_last: assert property (@(posedge clk) disable iff (rst)
        (col_valid_o && cfg.page) |-> !last_o);

    // R4/R5: upper column bits hold while a fixed burst advances
    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        (col_valid_o && !cfg.page && !load_i && !term_i && !last_o) |=>
            ((col_o & ~cfg.mask) == ($past(col_o) & ~cfg.mask)));

endmodule

// File: tb/burst_colgen_tb_top.sv
module burst_colgen_tb_top;

    localparam int NVEC = 10;

    // each entry: start[11:4], blen[3:1], btype[0]
    localparam logic [11:0] VEC [NVEC] = '{
        {8'h00, 3'd0, 1'b0},
        {8'h37, 3'd1, 1'b0},
        {8'h37, 3'd1, 1'b1},
        {8'h5A, 3'd2, 1'b0},
        {8'h5A, 3'd2, 1'b1},
        {8'hC5, 3'd3, 1'b0},
        {8'hC5, 3'd3, 1'b1},
        {8'h7E, 3'd3, 1'b0},
        {8'h42, 3'd5, 1'b1},
        {8'h19, 3'd6, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic       term_i = 1'b0;
    logic [2:0] blen_i = '0;
    logic       btype_i = 1'b0;
    logic [7:0] col_o;
    logic       col_valid_o;
    logic       last_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    burst_colgen dut_i (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load_i),
        .start_col_i (start_col_i),
        .term_i      (term_i),
        .blen_i      (blen_i),
        .btype_i     (btype_i),
        .col_o       (col_o),
        .col_valid_o (col_valid_o),
        .last_o      (last_o)
    );

    function automatic int blen_of(input logic [2:0] code);
        case (code)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] code,
                                           input logic typ, input int k);
        int len = blen_of(code);
        int lo;
        if (len == 0) return 8'((int'(s) + k) % 256);
        if (typ) lo = (int'(s) % len) ^ k;
        else     lo = (int'(s) % len + k) % len;
        return 8'((int'(s) / len) * len + lo);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic v, input logic [7:0] c,
                         input logic l, input logic [7:0] ec, input logic ev, input logic el);
        n_chk++;
        if (v !== ev || l !== el || (ev && c !== ec)) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b col=%02h last=%0b, expected valid=%0b col=%02h last=%0b",
                     req, v, c, l, ev, ec, el);
        end
    endtask

    task automatic do_load(input logic [7:0] s, input logic [2:0] code, input logic typ);
        load_i = 1'b1; start_col_i = s; blen_i = code; btype_i = typ;
        tick();
        load_i = 1'b0;
        // R11: scramble mode inputs during the burst
        blen_i = ~code; btype_i = ~typ; start_col_i = ~s;
    endtask

    initial begin
        #800000;
        $display("FAIL watchdog: got timeout, expected completion");
        n_bad++;
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        logic [2:0] code;
        logic       typ;
        int         len;

        // R1: reset state
        tick();
        check("R1", col_valid_o, col_o, last_o, 8'h00, 1'b0, 1'b0);
        rst = 1'b0;
        tick();
        check("R1", col_valid_o, col_o, last_o, 8'h00, 1'b0, 1'b0);

        // table walk: R2 R3 R4 R5 R6 R10 R11
        for (int i = 0; i < NVEC; i++) begin
            s = VEC[i][11:4]; code = VEC[i][3:1]; typ = VEC[i][0];
            len = blen_of(code);
            do_load(s, code, typ);
            for (int k = 0; k < len; k++) begin
                check(typ ? "R5" : "R4", col_valid_o, col_o, last_o,
                      exp_col(s, code, typ, k), 1'b1, k == len - 1);
                tick();
            end
            check("R6", col_valid_o, col_o, last_o, 8'h00, 1'b0, 1'b0);
            tick();
        end

        // R7: full page wraps past 256 beats, then R8 terminate
        do_load(8'hF0, 3'd7, 1'b1);
        for (int k = 0; k < 270; k++) begin
            check("R7", col_valid_o, col_o, last_o, exp_col(8'hF0, 3'd7, 1'b0, k), 1'b1, 1'b0);
            if (k == 269) term_i = 1'b1;
            tick();
        end
        term_i = 1'b0;
        check("R8", col_valid_o, col_o, last_o, 8'h00, 1'b0, 1'b0);
        tick();

        // R8: terminate mid fixed burst
        do_load(8'h13, 3'd3, 1'b0);
        check("R8", col_valid_o, col_o, last_o, 8'h13, 1'b1, 1'b0);
        tick();
        check("R8", col_valid_o, col_o, last_o, 8'h14, 1'b1, 1'b0);
        term_i = 1'b1;
        tick();
        term_i = 1'b0;
        check("R8", col_valid_o, col_o, last_o, 8'h00, 1'b0, 1'b0);
        tick();

        // R9: interrupt with a new column and new mode
        do_load(8'h05, 3'd2, 1'b1);
        check("R9", col_valid_o, col_o, last_o, 8'h05, 1'b1, 1'b0);
        tick();
        check("R9", col_valid_o, col_o, last_o, 8'h04, 1'b1, 1'b0);
        do_load(8'h2A, 3'd1, 1'b0);
        check("R9", col_valid_o, col_o, last_o, 8'h2A, 1'b1, 1'b0);
        tick();
        check("R9", col_valid_o, col_o, last_o, 8'h2B, 1'b1, 1'b1);
        tick();
        check("R9", col_valid_o, col_o, last_o, 8'h00, 1'b0, 1'b0);

        // R8: load wins over terminate in the same cycle
        do_load(8'h80, 3'd7, 1'b0);
        tick();
        term_i = 1'b1;
        do_load(8'h91, 3'd1, 1'b1);
        term_i = 1'b0;
        check("R8", col_valid_o, col_o, last_o, 8'h91, 1'b1, 1'b0);
        tick();
        check("R8", col_valid_o, col_o, last_o, 8'h90, 1'b1, 1'b1);

        // R6: load on the last beat chains directly into a new burst
        do_load(8'h66, 3'd0, 1'b0);
        check("R6", col_valid_o, col_o, last_o, 8'h66, 1'b1, 1'b1);
        tick();
        check("R6", col_valid_o, col_o, last_o, 8'h00, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule